// File: doc/BRIEF.md
# Single-Byte Open-Drain I2C Master

This block runs one complete I2C transaction for each command it accepts. A transaction either writes one data byte to a 7-bit target address or reads one data byte from it. Neither bus line is ever driven high. For each line the block has a pull-low enable output. It reads the real line level back through an input, and an external pull-up sets the released level.

A command gives a 7-bit address, a read/write select, a write byte and a one-cycle start strobe. The block returns the received byte and a busy flag. It also returns a one-cycle done pulse after the closing idle gap. Two sticky flags are kept. One records a missing acknowledge, and the other records a bus that was not idle when the command was taken. Each phase of the bus waveform has its own cycle-count parameter, and the defaults are derived from the clock frequency. The timing has three parts per bit: data setup with the clock low, clock released, and clock low hold. A missing acknowledge does not stop the transaction. The block still sends the remaining byte and the STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: While reset is applied and afterwards, both pull-low enables stay inactive (0) and busy stays 1. After reset is released, busy falls exactly POR_CYC+2 clock cycles later: 2 cycles for reset synchronisation, then the power-up wait.
- R2: When a command is accepted while SCL or SDA reads low, the bus-not-idle flag is set to 1. The transaction still runs to completion with unchanged timing.
- R3: START begins in the cycle after acceptance. The SDA enable is active and the SCL enable is inactive for HIGH_CYC cycles. The SCL enable then becomes active. While the SCL enable is inactive, the SDA enable rises only at START.
- R4: Every bit slot lasts SETUP_CYC+HIGH_CYC+HOLD_CYC cycles, with SCL released only in the middle phase. Bytes go out MSB first. The first byte is the address followed by a bit 0 that is 1 for read and 0 for write.
- R5: In a write, the second byte on the bus equals the write data.
- R6: In each acknowledge slot that the master receives, the master releases SDA and samples it at the end of the clock-high phase. A high level sets the missing-ack flag, and the transaction continues with unchanged length.
- R7: In a read, the master releases SDA for 8 bit slots and assembles the byte MSB first. It then drives SDA low in the acknowledge slot. The read data output takes the byte at done. A write leaves it unchanged.
- R8: STOP holds both enables active for SETUP_CYC cycles, releases SCL for HIGH_CYC cycles, and then releases SDA. An idle gap of GAP_CYC cycles with both lines released follows, and busy stays 1 through it.
- R9: A start strobe while busy is ignored: timing, bytes sent and flags are unaffected.
- R10: Both status flags are cleared in the cycle a new command is accepted. In that same cycle the bus-not-idle flag is reloaded from the sampled line levels.
- R11: Done is 1 for exactly one cycle, coinciding with busy falling. The first SCL enable rise comes after START, and done is due 2·HIGH_CYC+HOLD_CYC+SETUP_CYC+GAP_CYC+18·(SETUP_CYC+HIGH_CYC+HOLD_CYC) cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Command strobe, taken only when not busy |
| rd_i | input | 1 | 1 = read transaction, 0 = write transaction |
| addr_i | input | 7 | Target address |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Byte read by the last read transaction |
| busy_o | output | 1 | High during power-up wait and during a transaction including its gap |
| done_o | output | 1 | One-cycle pulse at the end of the idle gap |
| nack_o | output | 1 | Sticky: an acknowledge slot read high |
| bus_err_o | output | 1 | Sticky: a line was low when the command was accepted |
| scl_drive_o | output | 1 | 1 = pull SCL low |
| sda_drive_o | output | 1 | 1 = pull SDA low |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |

## Verification
Each phase takes a fixed number of cycles, so the bench computes the exact due cycle of every result from the acceptance edge. Those results are the START and STOP line levels, done, the busy fall and the flags. The bench then samples on the falling clock edge of that cycle and of its neighbours. The bench's bus target follows the real SCL edges rather than the clock. It captures the bytes the master sends and supplies the read byte and the acknowledges. The flags are compared in the cycle after acceptance. The read data is compared in the done cycle, and the busy-fall count after reset covers the two synchroniser cycles.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

  typedef enum logic [3:0] {
    ST_POR,
    ST_IDLE,
    ST_STA_A,
    ST_STA_B,
    ST_BIT_SU,
    ST_BIT_HI,
    ST_BIT_HO,
    ST_STO_A,
    ST_STO_B,
    ST_GAP
  } bm_state_e;

  localparam int unsigned SLOTS_PER_XFER = 18;
  localparam int unsigned ADDR_ACK_SLOT  = 8;
  localparam int unsigned DATA_ACK_SLOT  = 17;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2c_bm_timer.sv
module i2c_bm_timer #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load_i)
      cnt_n = load_val_i;
    else if (cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_n;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/i2c_bm_shifter.sv
module i2c_bm_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '1;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], ser_i};
  end

  assign q_o = sh_q;

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETUP_CYC = (CLK_HZ / 1_000_000) * 3,
  parameter int unsigned HIGH_CYC  = (CLK_HZ / 1_000_000) * 5,
  parameter int unsigned HOLD_CYC  = (CLK_HZ / 1_000_000) * 3,
  parameter int unsigned GAP_CYC   = CLK_HZ / 1_000,
  parameter int unsigned POR_CYC   = CLK_HZ / 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic [6:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_o,
  output logic       bus_err_o,
  output logic       scl_drive_o,
  output logic       sda_drive_o,
  input  logic       scl_i,
  input  logic       sda_i
);

  localparam int unsigned MAX_CYC = imax(imax(imax(SETUP_CYC, HIGH_CYC), imax(HOLD_CYC, GAP_CYC)), POR_CYC);
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] SU_L  = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] HI_L  = TW'(HIGH_CYC - 1);
  localparam logic [TW-1:0] HO_L  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] GAP_L = TW'(GAP_CYC - 1);
  localparam int unsigned SW      = $clog2(SLOTS_PER_XFER);
  localparam logic [SW-1:0] SLOT_AACK = SW'(ADDR_ACK_SLOT);
  localparam logic [SW-1:0] SLOT_DACK = SW'(DATA_ACK_SLOT);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bm_state_e     st_q, st_n;
  logic [SW-1:0] slot_q, slot_n;
  logic          rd_q, nack_q, berr_q, done_q;
  logic [7:0]    wdata_q, rdata_q;

  logic          tmr_ld, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          sh_ld, sh_shift;
  logic [7:0]    sh_val, sh_q;
  logic          accept, nack_set, done_n, rdata_ld;

  i2c_bm_timer #(.W(TW), .RST_VAL(POR_CYC - 1)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync),
    .load_i     (tmr_ld),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  i2c_bm_shifter #(.W(8)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync),
    .load_i     (sh_ld),
    .load_val_i (sh_val),
    .shift_i    (sh_shift),
    .ser_i      (sda_i),
    .q_o        (sh_q)
  );

  logic ack_slot, rx_ack_slot, tx_ack_slot;
  assign ack_slot    = (slot_q == SLOT_AACK) || (slot_q == SLOT_DACK);
  assign tx_ack_slot = (slot_q == SLOT_DACK) && rd_q;
  assign rx_ack_slot = ack_slot && !tx_ack_slot;

  // next-state logic
  always_comb begin
    st_n     = st_q;
    slot_n   = slot_q;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    sh_ld    = 1'b0;
    sh_val   = 8'hFF;
    sh_shift = 1'b0;
    accept   = 1'b0;
    nack_set = 1'b0;
    done_n   = 1'b0;
    rdata_ld = 1'b0;
    unique case (st_q)
      ST_POR: if (tmr_exp) st_n = ST_IDLE;
      ST_IDLE: if (start_i) begin
        st_n    = ST_STA_A;
        tmr_ld  = 1'b1;
        tmr_val = HI_L;
        accept  = 1'b1;
        sh_ld   = 1'b1;
        sh_val  = {addr_i, rd_i};
      end
      ST_STA_A: if (tmr_exp) begin
        st_n = ST_STA_B; tmr_ld = 1'b1; tmr_val = HO_L;
      end
      ST_STA_B: if (tmr_exp) begin
        st_n = ST_BIT_SU; tmr_ld = 1'b1; tmr_val = SU_L; slot_n = '0;
      end
      ST_BIT_SU: if (tmr_exp) begin
        st_n = ST_BIT_HI; tmr_ld = 1'b1; tmr_val = HI_L;
      end
      ST_BIT_HI: if (tmr_exp) begin
        st_n     = ST_BIT_HO;
        tmr_ld   = 1'b1;
        tmr_val  = HO_L;
        sh_shift = !ack_slot;
        nack_set = rx_ack_slot && sda_i;
      end
      ST_BIT_HO: if (tmr_exp) begin
        tmr_ld  = 1'b1;
        tmr_val = SU_L;
        if (slot_q == SLOT_DACK) begin
          st_n = ST_STO_A;
        end else begin
          st_n   = ST_BIT_SU;
          slot_n = slot_q + 1'b1;
          if (slot_q == SLOT_AACK) begin
            sh_ld  = 1'b1;
            sh_val = rd_q ? 8'hFF : wdata_q;
          end
        end
      end
      ST_STO_A: if (tmr_exp) begin
        st_n = ST_STO_B; tmr_ld = 1'b1; tmr_val = HI_L;
      end
      ST_STO_B: if (tmr_exp) begin
        st_n = ST_GAP; tmr_ld = 1'b1; tmr_val = GAP_L;
      end
      ST_GAP: if (tmr_exp) begin
        st_n     = ST_IDLE;
        done_n   = 1'b1;
        rdata_ld = rd_q;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      st_q    <= ST_POR;
      slot_q  <= '0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      nack_q  <= 1'b0;
      berr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      slot_q <= slot_n;
      done_q <= done_n;
      if (accept) begin
        rd_q    <= rd_i;
        wdata_q <= wdata_i;
        berr_q  <= !(scl_i && sda_i);
      end
      if (accept)        nack_q  <= 1'b0;
      else if (nack_set) nack_q  <= 1'b1;
      if (rdata_ld)      rdata_q <= sh_q;
    end
  end

  // line drive decode
  always_comb begin
    sda_drive_o = 1'b0;
    scl_drive_o = 1'b0;
    unique case (st_q)
      ST_STA_A:  sda_drive_o = 1'b1;
      ST_STA_B,
      ST_STO_A: begin sda_drive_o = 1'b1; scl_drive_o = 1'b1; end
      ST_STO_B:  sda_drive_o = 1'b1;
      ST_BIT_SU,
      ST_BIT_HI,
      ST_BIT_HO: begin
        scl_drive_o = (st_q != ST_BIT_HI);
        if (tx_ack_slot)      sda_drive_o = 1'b1;
        else if (rx_ack_slot) sda_drive_o = (st_q == ST_BIT_HO);
        else                  sda_drive_o = !sh_q[7];
      end
      default: ;
    endcase
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign nack_o    = nack_q;
  assign bus_err_o = berr_q;
  assign rdata_o   = rdata_q;

endmodule

// File: rtl/i2c_bm_checker.sv
module i2c_bm_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic nack_o,
  input logic scl_drive_o,
  input logic sda_drive_o
);

  // R1: nothing pulls a line while no command is in progress
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_drive_o && !sda_drive_o));

  // R3: SDA pulled low with SCL released only as START from idle
  p_start_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_drive_o) && !scl_drive_o) |-> !$past(busy_o));

  // R8: SDA released with SCL released only after SCL was already up (STOP)
  p_stop_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_drive_o) && !scl_drive_o) |-> (busy_o && !$past(scl_drive_o)));

  // R11: done is a single-cycle pulse with busy low
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10: accepting a command clears the missing-ack flag
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !nack_o));

endmodule

bind i2c_byte_master i2c_bm_checker u_bm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .nack_o      (nack_o),
  .scl_drive_o (scl_drive_o),
  .sda_drive_o (sda_drive_o)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;

  localparam int SU  = 3;
  localparam int HI  = 5;
  localparam int HO  = 3;
  localparam int GAP = 40;
  localparam int POR = 60;
  localparam int T   = HI + HO + 18 * (SU + HI + HO) + SU + HI + GAP;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, rd_i;
  logic [6:0] addr_i;
  logic [7:0] wdata_i, rdata_o;
  logic busy_o, done_o, nack_o, bus_err_o, scl_drive_o, sda_drive_o;
  logic slv_sda, tb_sda_hold;
  logic scl_line, sda_line;

  assign scl_line = !scl_drive_o;
  assign sda_line = !(sda_drive_o || slv_sda || tb_sda_hold);

  always #10 clk = !clk;

  i2c_byte_master #(
    .SETUP_CYC(SU), .HIGH_CYC(HI), .HOLD_CYC(HO), .GAP_CYC(GAP), .POR_CYC(POR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o),
    .nack_o(nack_o), .bus_err_o(bus_err_o), .scl_drive_o(scl_drive_o),
    .sda_drive_o(sda_drive_o), .scl_i(scl_line), .sda_i(sda_line)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] cap_addr, cap_data, exp_rdata;
  logic cap_mack;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic bit exp_nack(input bit rd, input bit ack_a, input bit ack_d);
    return !ack_a || (!rd && !ack_d);
  endfunction

  // bus target: follows SCL edges, captures bytes, drives acks and read data
  task automatic slave_txn(input bit rd, input bit ack_a, input bit ack_d, input logic [7:0] rbyte);
    @(negedge scl_line);
    for (int s = 0; s < 18; s++) begin
      slv_sda = 1'b0;
      if (s == 8) slv_sda = ack_a;
      else if (s >= 9 && s <= 16 && rd) slv_sda = !rbyte[16 - s];
      else if (s == 17 && !rd) slv_sda = ack_d;
      @(posedge scl_line);
      if (s < 8) cap_addr = {cap_addr[6:0], sda_line};
      else if (s >= 9 && s <= 16) cap_data = {cap_data[6:0], sda_line};
      else if (s == 17) cap_mack = !sda_line;
      @(negedge scl_line);
    end
    slv_sda = 1'b0;
  endtask

  task automatic drive_txn(input logic [6:0] a, input bit rd, input logic [7:0] wd,
                           input bit hold_bus, input bit poke, input bit nk);
    @(negedge clk);
    addr_i = a; rd_i = rd; wdata_i = wd; start_i = 1'b1;
    if (hold_bus) tb_sda_hold = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    tb_sda_hold = 1'b0;
    chk("R10 busy after accept", busy_o, 1);
    chk("R10 nack cleared", nack_o, 0);
    chk("R2 bus_err flag", bus_err_o, hold_bus);
    chk("R3 START sda", sda_drive_o, 1);
    chk("R3 START scl", scl_drive_o, 0);
    for (int i = 1; i <= T + 1; i++) begin
      @(negedge clk);
      if (poke && i == 20) begin
        start_i = 1'b1; addr_i = ~a; rd_i = !rd; wdata_i = ~wd;
      end
      if (poke && i == 21) start_i = 1'b0;
      if (i == HI - 1) chk("R3 scl still released", scl_drive_o, 0);
      if (i == HI)     chk("R3 scl pulled after START", scl_drive_o, 1);
      if (i == HI + HO + SU) chk("R4 first high phase", scl_drive_o, 0);
      if (i == HI + HO + SU - 1) chk("R4 setup phase", scl_drive_o, 1);
      if (i == T - GAP - HI - 1) chk("R8 STOP low scl", scl_drive_o, 1);
      if (i == T - GAP - HI - 1) chk("R8 STOP low sda", sda_drive_o, 1);
      if (i == T - GAP - 1) chk("R8 STOP scl released", scl_drive_o, 0);
      if (i == T - GAP - 1) chk("R8 STOP sda held", sda_drive_o, 1);
      if (i == T - GAP) chk("R8 sda released", sda_drive_o, 0);
      if (i == T - 1) chk("R8 busy in gap", busy_o, 1);
      if (i == T - 1) chk("R11 no early done", done_o, 0);
      if (i == T) begin
        chk("R11 done due", done_o, 1);
        chk("R11 busy falls", busy_o, 0);
        chk("R6 nack flag", nack_o, nk);
        chk("R7 rdata", rdata_o, exp_rdata);
      end
      if (i == T + 1) chk("R11 done one cycle", done_o, 0);
    end
  endtask

  task automatic run_txn(input logic [6:0] a, input bit rd, input logic [7:0] wd,
                         input bit ack_a, input bit ack_d, input logic [7:0] rbyte,
                         input bit hold_bus, input bit poke);
    bit nk;
    nk = exp_nack(rd, ack_a, ack_d);
    if (rd) exp_rdata = rbyte;
    fork
      slave_txn(rd, ack_a, ack_d, rbyte);
      drive_txn(a, rd, wd, hold_bus, poke, nk);
    join
    chk("R4 address byte MSB first with rw bit", cap_addr, {a, rd});
    if (rd) chk("R7 master ack low", cap_mack, 1);
    else    chk("R5 write byte", cap_data, wd);
    if (poke) chk("R9 start while busy ignored", cap_addr, {a, rd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1c2b);
    rst_n = 1'b0; start_i = 1'b0; rd_i = 1'b0; addr_i = '0; wdata_i = '0;
    slv_sda = 1'b0; tb_sda_hold = 1'b0; exp_rdata = '0;
    cap_addr = '0; cap_data = '0; cap_mack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 scl released in reset", scl_drive_o, 0);
    chk("R1 sda released in reset", sda_drive_o, 0);
    chk("R1 busy in reset", busy_o, 1);
    rst_n = 1'b1;
    for (int i = 1; i <= POR + 2; i++) begin
      @(negedge clk);
      if (i == POR + 1) chk("R1 busy during power-up", busy_o, 1);
      if (i == POR + 2) chk("R1 ready after power-up", busy_o, 0);
    end
    chk("R1 lines released after power-up", {scl_drive_o, sda_drive_o}, 0);

    // directed cases
    run_txn(7'h50, 1'b0, 8'hA5, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);  // plain write
    run_txn(7'h2B, 1'b1, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0);  // plain read
    run_txn(7'h7F, 1'b0, 8'h81, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);  // R6 address nack
    run_txn(7'h00, 1'b0, 8'hFF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);  // R6 data nack
    run_txn(7'h11, 1'b1, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0);  // read with address nack
    run_txn(7'h33, 1'b0, 8'h5A, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0);  // R2 bus held low
    run_txn(7'h44, 1'b1, 8'h00, 1'b1, 1'b1, 8'h96, 1'b0, 1'b1);  // R9 poke while busy
    run_txn(7'h45, 1'b0, 8'h01, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);  // R10 flags cleared

    // random mix
    for (int k = 0; k < 8; k++) begin
      logic [6:0] ra;
      logic [7:0] rw, rb;
      bit rrd, raa, rad;
      ra  = 7'($urandom);
      rw  = 8'($urandom);
      rb  = 8'($urandom);
      rrd = 1'($urandom);
      raa = ($urandom % 4) != 0;
      rad = ($urandom % 4) != 0;
      run_txn(ra, rrd, rw, raa, rad, rb, 1'b0, 1'b0);
    end
    summary();
  end

endmodule